// File: doc/BRIEF.md
# Dual-Modulus Pulse-Swallow Feedback Divider

This block is the integer-N feedback divider of a frequency synthesizer, modelled in digital logic. It divides a fast input clock by N = B·P + A. P is the lower modulus of a two-modulus prescaler, B is a 13-bit main count and A is a 5-bit swallow count. Each divide cycle has B prescaler periods. The first A periods run at P+1 and the remaining periods run at P. On the last input clock of every cycle the block emits a one-clock pulse.

The prescaler is modelled as a down-counter clocked by the input clock. A control state machine counts its periods. State `ST_SWALLOW` drives the modulus-control output high, and state `ST_MAIN` drives it low. The transition `ST_SWALLOW → ST_MAIN` happens when the final swallow period ends. At every cycle boundary and during reset there is a restart transition into `ST_SWALLOW` when the next A is nonzero, or into `ST_MAIN` when it is zero.

New settings are presented with a load strobe and held in a shadow register. They are copied into the active set only at a cycle boundary, so no cycle is ever cut short or stretched by a write. A range checker examines the setting presently in force and raises two flags: one for an illegal setting, and one for a ratio below the contiguous range.

Top module: `swallow_divider`

## Requirements
- R1: When the active setting has A ≤ B, the interval between consecutive `div_pulse` assertions is exactly B·P + A input clocks.
- R2: `pre_sel` selects P as follows: 2'b00 gives 8, 2'b01 gives 16, and both 2'b10 and 2'b11 give 32.
- R3: `div_pulse` is high for exactly one input clock, on the last clock of each cycle. After reset is released, the first pulse falls on clock N.
- R4: Within a cycle, `mod_ctl` is high during the first min(A,B) prescaler periods, which is min(A,B)·(P+1) clocks, and low for the rest of the cycle. It changes only at a prescaler period edge.
- R5: Values captured by `load` become active at the next cycle boundary. A load during the last clock of a cycle applies to the very next cycle. A load anywhere else leaves the length of the current cycle unchanged.
- R6: When several loads occur within one cycle, the last one wins. Without a new load, the active setting repeats from cycle to cycle.
- R7: Synchronous reset sets the active setting to the defaults sel = 2'b00, B = 7, A = 0 (N = 56). During reset `div_pulse`, `mod_ctl`, `cfg_bad` and `non_contig` are all low.
- R8: `cfg_bad` is high while the active setting has B < 3 or A > B. When A > B, all B periods use P+1, so the cycle lasts B·(P+1) clocks.
- R9: `non_contig` is high while the active setting has B·P + A < P² − P. Both flags follow the active setting, so they change only at a cycle boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast input clock (prescaler input) |
| rst | input | 1 | Synchronous active-high reset |
| load | input | 1 | Capture `pre_sel`, `b_val` and `a_val` into the shadow setting |
| pre_sel | input | 2 | Prescaler modulus select |
| b_val | input | 13 | Main count B |
| a_val | input | 5 | Swallow count A |
| div_pulse | output | 1 | One-clock pulse on the last clock of each divide cycle |
| mod_ctl | output | 1 | Modulus control; high selects P+1 |
| cfg_bad | output | 1 | Active setting is illegal (B < 3 or A > B) |
| non_contig | output | 1 | Active ratio is below the contiguous minimum P² − P |

## Verification
On every cycle, the embedded properties check that the output pulse never lasts two clocks and that modulus control only falls at a prescaler period edge. They also check that modulus control is already low at the end of any cycle whose swallow count is below its main count, and that the active setting never moves except right after a boundary. Other behaviours can only be shown by the scenarios: the exact pulse spacing for each prescaler select including the duplicate code, the number of high modulus-control clocks per cycle, the way a load in the boundary clock differs from mid-cycle loads where the last one wins, and the flag values for settings on and below the contiguous limit and with A above B.

// File: rtl/swallow_div_pkg.sv
package swallow_div_pkg;

    localparam int SEL_W = 2;
    localparam int PM_W  = 6;

    typedef enum logic [0:0] {
        ST_SWALLOW = 1'b0,
        ST_MAIN    = 1'b1
    } swl_state_e;

    function automatic logic [PM_W-1:0] pre_modulus(input logic [SEL_W-1:0] sel);
        logic [PM_W-1:0] p;
        case (sel)
            2'b00:   p = PM_W'(8);
            2'b01:   p = PM_W'(16);
            default: p = PM_W'(32);
        endcase
        return p;
    endfunction

endpackage

// File: rtl/swallow_range_chk.sv
module swallow_range_chk
    import swallow_div_pkg::*;
#(
    parameter int B_W = 13,
    parameter int A_W = 5
) (
    input  logic [SEL_W-1:0] sel,
    input  logic [B_W-1:0]   b_cnt,
    input  logic [A_W-1:0]   a_cnt,
    output logic             cfg_bad,
    output logic             non_contig
);
    localparam int N_W = B_W + PM_W + 1;
    localparam int B_MIN = 3;

    logic [PM_W-1:0] p_val;
    logic [N_W-1:0]  n_val;
    logic [N_W-1:0]  n_floor;

    always_comb begin
        p_val      = pre_modulus(sel);
        n_val      = N_W'(b_cnt) * N_W'(p_val) + N_W'(a_cnt);
        n_floor    = N_W'(p_val) * N_W'(p_val) - N_W'(p_val);
        cfg_bad    = (b_cnt < B_W'(B_MIN)) || (B_W'(a_cnt) > b_cnt);
        non_contig = n_val < n_floor;
    end

endmodule

// File: rtl/swallow_cfg_hold.sv
module swallow_cfg_hold
    import swallow_div_pkg::*;
#(
    parameter int             B_W     = 13,
    parameter int             A_W     = 5,
    parameter logic [SEL_W-1:0] DEF_SEL = 2'b00,
    parameter int             DEF_B   = 7,
    parameter int             DEF_A   = 0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic             boundary,
    input  logic [SEL_W-1:0] sel_in,
    input  logic [B_W-1:0]   b_in,
    input  logic [A_W-1:0]   a_in,
    output logic [SEL_W-1:0] sel_act,
    output logic [B_W-1:0]   b_act,
    output logic [A_W-1:0]   a_act,
    output logic [SEL_W-1:0] sel_nxt,
    output logic [B_W-1:0]   b_nxt,
    output logic [A_W-1:0]   a_nxt
);
    logic [SEL_W-1:0] sel_sh;
    logic [B_W-1:0]   b_sh;
    logic [A_W-1:0]   a_sh;

    // Setting that the next cycle will use
    always_comb begin
        if (rst) begin
            sel_nxt = DEF_SEL;
            b_nxt   = B_W'(DEF_B);
            a_nxt   = A_W'(DEF_A);
        end else if (load) begin
            sel_nxt = sel_in;
            b_nxt   = b_in;
            a_nxt   = a_in;
        end else begin
            sel_nxt = sel_sh;
            b_nxt   = b_sh;
            a_nxt   = a_sh;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_sh  <= DEF_SEL;
            b_sh    <= B_W'(DEF_B);
            a_sh    <= A_W'(DEF_A);
            sel_act <= DEF_SEL;
            b_act   <= B_W'(DEF_B);
            a_act   <= A_W'(DEF_A);
        end else begin
            if (load) begin
                sel_sh <= sel_in;
                b_sh   <= b_in;
                a_sh   <= a_in;
            end
            if (boundary) begin
                sel_act <= sel_nxt;
                b_act   <= b_nxt;
                a_act   <= a_nxt;
            end
        end
    end

    // R5
    cfg_stable_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(boundary)) |->
            ($stable(sel_act) && $stable(b_act) && $stable(a_act)));

endmodule

// File: rtl/swallow_prescaler.sv
module swallow_prescaler
    import swallow_div_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic [PM_W-1:0] reload_val,
    output logic            tick
);
    logic [PM_W-1:0] cnt_q;

    assign tick = (cnt_q == '0);

    always_ff @(posedge clk) begin
        if (rst || tick) begin
            cnt_q <= reload_val;
        end else begin
            cnt_q <= cnt_q - PM_W'(1);
        end
    end

endmodule

// File: rtl/swallow_ctrl.sv
module swallow_ctrl
    import swallow_div_pkg::*;
#(
    parameter int B_W = 13,
    parameter int A_W = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic [SEL_W-1:0] sel_act,
    input  logic [SEL_W-1:0] sel_nxt,
    input  logic [B_W-1:0]   b_nxt,
    input  logic [A_W-1:0]   a_nxt,
    output logic             boundary,
    output logic             mod_ctl,
    output logic [PM_W-1:0]  reload_val
);
    swl_state_e      state_q, state_d;
    logic [A_W-1:0]  acnt_q, acnt_d;
    logic [B_W-1:0]  bcnt_q, bcnt_d;
    logic            restart;
    logic [PM_W-1:0] p_use;

    // Outputs
    always_comb begin
        boundary = tick && (bcnt_q == B_W'(1));
        mod_ctl  = (state_q == ST_SWALLOW);
        restart  = rst || boundary;
    end

    // Next state and counters
    always_comb begin
        state_d = state_q;
        acnt_d  = acnt_q;
        bcnt_d  = bcnt_q;
        if (restart) begin
            state_d = (a_nxt != '0) ? ST_SWALLOW : ST_MAIN;
            acnt_d  = a_nxt;
            bcnt_d  = b_nxt;
        end else begin
            if (tick) begin
                bcnt_d = bcnt_q - B_W'(1);
            end
            unique case (state_q)
                ST_SWALLOW: begin
                    if (tick) begin
                        acnt_d = acnt_q - A_W'(1);
                        if (acnt_q == A_W'(1)) begin
                            state_d = ST_MAIN;
                        end
                    end
                end
                ST_MAIN: begin
                end
            endcase
        end
    end

    // Prescaler reload for the period that starts next
    always_comb begin
        p_use      = restart ? pre_modulus(sel_nxt) : pre_modulus(sel_act);
        reload_val = (state_d == ST_SWALLOW) ? p_use : (p_use - PM_W'(1));
    end

    // State register
    always_ff @(posedge clk) begin
        state_q <= state_d;
        acnt_q  <= acnt_d;
        bcnt_q  <= bcnt_d;
    end

    // R4
    mod_fall_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(mod_ctl) |-> $past(tick));

endmodule

// File: rtl/swallow_divider.sv
module swallow_divider
    import swallow_div_pkg::*;
#(
    parameter int               B_W     = 13,
    parameter int               A_W     = 5,
    parameter logic [SEL_W-1:0] DEF_SEL = 2'b00,
    parameter int               DEF_B   = 7,
    parameter int               DEF_A   = 0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [SEL_W-1:0] pre_sel,
    input  logic [B_W-1:0]   b_val,
    input  logic [A_W-1:0]   a_val,
    output logic             div_pulse,
    output logic             mod_ctl,
    output logic             cfg_bad,
    output logic             non_contig
);
    logic [SEL_W-1:0] sel_act, sel_nxt;
    logic [B_W-1:0]   b_act, b_nxt;
    logic [A_W-1:0]   a_act, a_nxt;
    logic             boundary;
    logic             tick;
    logic [PM_W-1:0]  reload_val;

    swallow_cfg_hold #(
        .B_W(B_W), .A_W(A_W),
        .DEF_SEL(DEF_SEL), .DEF_B(DEF_B), .DEF_A(DEF_A)
    ) u_cfg (
        .clk(clk), .rst(rst), .load(load), .boundary(boundary),
        .sel_in(pre_sel), .b_in(b_val), .a_in(a_val),
        .sel_act(sel_act), .b_act(b_act), .a_act(a_act),
        .sel_nxt(sel_nxt), .b_nxt(b_nxt), .a_nxt(a_nxt)
    );

    swallow_prescaler u_pre (
        .clk(clk), .rst(rst), .reload_val(reload_val), .tick(tick)
    );

    swallow_ctrl #(.B_W(B_W), .A_W(A_W)) u_ctrl (
        .clk(clk), .rst(rst), .tick(tick),
        .sel_act(sel_act), .sel_nxt(sel_nxt), .b_nxt(b_nxt), .a_nxt(a_nxt),
        .boundary(boundary), .mod_ctl(mod_ctl), .reload_val(reload_val)
    );

    swallow_range_chk #(.B_W(B_W), .A_W(A_W)) u_rng (
        .sel(sel_act), .b_cnt(b_act), .a_cnt(a_act),
        .cfg_bad(cfg_bad), .non_contig(non_contig)
    );

    assign div_pulse = boundary;

    // R3
    pulse_width_chk: assert property (@(posedge clk) disable iff (rst)
        div_pulse |=> !div_pulse);

    // R4
    mod_end_chk: assert property (@(posedge clk) disable iff (rst)
        (div_pulse && (B_W'(a_act) < b_act)) |-> !mod_ctl);

endmodule

// File: tb/sim_swallow_divider.sv
module sim_swallow_divider;

    typedef struct {
        int    len;
        int    mhi;
        bit    bad;
        bit    nc;
        string tag;
    } item_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        load = 1'b0;
    logic [1:0]  pre_sel = 2'b00;
    logic [12:0] b_val = '0;
    logic [4:0]  a_val = '0;
    logic        div_pulse, mod_ctl, cfg_bad, non_contig;

    int    checks = 0;
    int    errors = 0;
    bit    finished = 1'b0;
    item_t exp_q[$];

    always #4 clk = ~clk;

    swallow_divider u0 (
        .clk(clk), .rst(rst), .load(load), .pre_sel(pre_sel),
        .b_val(b_val), .a_val(a_val), .div_pulse(div_pulse),
        .mod_ctl(mod_ctl), .cfg_bad(cfg_bad), .non_contig(non_contig)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic item_t mk(input int sel, input int b, input int a, input string tag);
        item_t it;
        int p  = (sel == 0) ? 8 : ((sel == 1) ? 16 : 32);
        int sw = (a < b) ? a : b;
        it.len = b * p + sw;
        it.mhi = sw * (p + 1);
        it.bad = (b < 3) || (a > b);
        it.nc  = (b * p + a) < (p * p - p);
        it.tag = tag;
        return it;
    endfunction

    task automatic wait_pulse();
        do @(negedge clk); while (!div_pulse);
    endtask

    // Monitor: measures each cycle and compares with the scoreboard
    initial begin
        int cnt = 0;
        int mhi = 0;
        bit prev = 1'b0;
        item_t it;
        forever begin
            @(negedge clk);
            if (rst) begin
                cnt = 0; mhi = 0; prev = 1'b0;
            end else begin
                cnt++;
                if (mod_ctl) mhi++;
                if (prev) chk(!div_pulse, "R3 pulse one clock wide", int'(div_pulse), 0);
                prev = div_pulse;
                if (div_pulse) begin
                    if (exp_q.size() == 0) begin
                        chk(1'b0, "R1 unexpected pulse", cnt, 0);
                    end else begin
                        it = exp_q.pop_front();
                        chk(cnt == it.len, {"R1 cycle length ", it.tag}, cnt, it.len);
                        chk(mhi == it.mhi, {"R4 mod_ctl high clocks ", it.tag}, mhi, it.mhi);
                        chk(cfg_bad == it.bad, {"R8 cfg_bad ", it.tag}, int'(cfg_bad), int'(it.bad));
                        chk(non_contig == it.nc, {"R9 non_contig ", it.tag}, int'(non_contig), int'(it.nc));
                    end
                    cnt = 0; mhi = 0;
                end
            end
        end
    end

    // Driver
    localparam int NSTEP = 11;
    int    st_sel [NSTEP] = '{0, 1, 2, 3, 3, 0, 0, 1, 1, 0, 2};
    int    st_b   [NSTEP] = '{10, 20, 31, 31, 30, 3, 2, 4, 4, 7, 100};
    int    st_a   [NSTEP] = '{3, 5, 31, 0, 31, 0, 1, 2, 2, 0, 17};
    int    st_k   [NSTEP] = '{0, 0, 0, 0, 0, 0, 0, 1, 2, 0, 0};
    string st_tag [NSTEP] = '{"R1 P=8", "R2 P=16", "R4 A equals B", "R2 dup select R9 at limit",
                              "R8 A above B", "R9 below limit", "R8 B below 3",
                              "R5 mid-cycle load", "R6 last load wins", "R7 back to default",
                              "R2 P=32 long"};

    initial begin
        int sh_sel = 0;
        int sh_b = 7;
        int sh_a = 0;
        exp_q.push_back(mk(0, 7, 0, "R7 default after reset"));
        repeat (4) @(posedge clk);
        @(negedge clk);
        // R7 reset state
        chk(div_pulse == 1'b0, "R7 div_pulse in reset", int'(div_pulse), 0);
        chk(mod_ctl == 1'b0, "R7 mod_ctl in reset", int'(mod_ctl), 0);
        chk(cfg_bad == 1'b0, "R7 cfg_bad in reset", int'(cfg_bad), 0);
        chk(non_contig == 1'b0, "R7 non_contig in reset", int'(non_contig), 0);
        @(posedge clk);
        #2 rst = 1'b0;

        for (int s = 0; s < NSTEP; s++) begin
            wait_pulse();
            if (st_k[s] == 0) begin
                // R5: load in the boundary clock applies to the next cycle
                load = 1'b1;
                pre_sel = 2'(st_sel[s]); b_val = 13'(st_b[s]); a_val = 5'(st_a[s]);
                sh_sel = st_sel[s]; sh_b = st_b[s]; sh_a = st_a[s];
                exp_q.push_back(mk(sh_sel, sh_b, sh_a, st_tag[s]));
                @(negedge clk);
                load = 1'b0;
                pre_sel = 2'b10; b_val = 13'd999; a_val = 5'd9;
            end else if (st_k[s] == 1) begin
                // R5, R6: two loads inside a cycle leave it unchanged
                exp_q.push_back(mk(sh_sel, sh_b, sh_a, st_tag[s]));
                repeat (3) @(negedge clk);
                load = 1'b1; pre_sel = 2'b10; b_val = 13'd500; a_val = 5'd9;
                @(negedge clk);
                load = 1'b0;
                repeat (2) @(negedge clk);
                load = 1'b1;
                pre_sel = 2'(st_sel[s]); b_val = 13'(st_b[s]); a_val = 5'(st_a[s]);
                @(negedge clk);
                load = 1'b0;
                sh_sel = st_sel[s]; sh_b = st_b[s]; sh_a = st_a[s];
            end else begin
                exp_q.push_back(mk(sh_sel, sh_b, sh_a, st_tag[s]));
            end
        end
        wait_pulse();
        @(negedge clk);
        chk(exp_q.size() == 0, "R1 all cycles observed", exp_q.size(), 0);
        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(100000 * 8);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule